// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Dispatcher

This block sits between an instruction decoder and two execution pipes, called X and Y. Each clock the decoder presents up to two decoded instructions in program order: an older slot and a younger slot. The block decides which instructions issue that cycle and which pipe each one goes to. It reports back how many instructions it consumed, so the decoder can shift the rest forward.

Every instruction carries a class tag: simple, branch, floating point or exclusive. Branch, floating-point and exclusive instructions may only run in the X pipe. An exclusive instruction always issues alone. Simple instructions pair freely, even when the younger one reads or writes a register that the older one touches. When both instructions issue together, the older one always takes X.

A lone simple instruction is steered by a load-balancing choice. The block keeps a saturating occupancy counter for each pipe. A counter goes up when an instruction issues to its pipe and goes down when that pipe reports a retirement.

The design is purely combinational from its inputs and the counters to its outputs. Only the counters are registered.

Top module: `pair_dispatch`

## Requirements
- R1: After reset both occupancy counters are zero. A lone simple instruction issued in the first cycle after reset therefore goes to X, because ties go to X.
- R2: While `stall_x` or `stall_y` is high, `x_vld` and `y_vld` are low and `consumed` is 0. The occupancy counters do not count an issue in that cycle.
- R3: An instruction of class branch (1) or floating point (2) in the older slot goes to X. If the younger slot is valid and simple (0), the younger one goes to Y in the same cycle and `consumed` is 2.
- R4: An exclusive instruction (class 3) in the older slot goes to X alone. `y_vld` is low and `consumed` is 1, whatever the younger slot holds.
- R5: Two valid simple instructions issue together: the older to X and the younger to Y, with `consumed` 2. Their payloads pass through unchanged even when the younger reads the older's destination register.
- R6: A simple older instruction with a valid younger instruction of class 1, 2 or 3 issues alone with `consumed` 1. The younger one is left in place for the next cycle.
- R7: A simple older instruction that issues alone goes to Y only when the Y counter is strictly lower than the X counter. Otherwise it goes to X.
- R8: Each pipe's counter rises by one on an issue without a retire and falls by one on a retire without an issue. It holds when both or neither happen. It saturates at 0 and at 2^CNT_W-1.
- R9: When the older slot is not valid, nothing issues and `consumed` is 0, even if the younger slot is valid.
- R10: A branch or floating-point older instruction whose younger partner is not simple issues alone to X with `consumed` 1.

Instruction word layout (INSTR_W = 2 + 3*REG_W): bits [1:0] hold the class. Above the class come the destination, the first source and the second source, each REG_W bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_ins | input | INSTR_W | Older instruction word |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_ins | input | INSTR_W | Younger instruction word |
| stall_x | input | 1 | X pipe cannot accept |
| stall_y | input | 1 | Y pipe cannot accept |
| retire_x | input | 1 | X pipe finished one instruction |
| retire_y | input | 1 | Y pipe finished one instruction |
| x_vld | output | 1 | Instruction issued to X |
| x_ins | output | INSTR_W | Word issued to X |
| y_vld | output | 1 | Instruction issued to Y |
| y_ins | output | INSTR_W | Word issued to Y |
| consumed | output | 2 | Instructions taken this cycle (0..2) |

## Verification
The bench steps through every combination of older and younger class, with the younger slot both present and absent. This separates the pairing rule from the X-only rule and from the exclusive-alone rule. Dependent simple pairs are offered to show that register overlap never blocks pairing. Long runs of branches to X, followed by retire pulses on one pipe or the other, drive the counters to both saturation limits. After each run a lone simple instruction is offered, so the counter state shows up in the pipe it is steered to. Stalls and a missing older slot are mixed in, and steering just after them shows that no issue was counted.

// File: rtl/pair_dispatch_pkg.sv
package pair_dispatch_pkg;
  typedef enum logic [1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_FLOAT  = 2'd2,
    CLS_EXCL   = 2'd3
  } ins_class_e;

  // Class must run in the X pipe.
  function automatic logic needs_x(input logic [1:0] cls);
    return cls != CLS_SIMPLE;
  endfunction

  // Load balance: Y wins only when strictly less loaded.
  function automatic logic lean_to_y(input logic [7:0] load_x, input logic [7:0] load_y);
    return load_y < load_x;
  endfunction
endpackage

// File: rtl/pipe_load_counter.sv
module pipe_load_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  wire at_top  = (count == TOP);
  wire at_zero = (count == '0);
  wire bump_up = issue && !retire && !at_top;
  wire bump_dn = retire && !issue && !at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (bump_up) count <= count + 1'b1;
    else if (bump_dn) count <= count - 1'b1;
  end

  // R8
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !retire && count != TOP) |=> count == $past(count) + 1'b1);
  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue == retire) |=> $stable(count));
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import pair_dispatch_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             old_vld,
  input  logic [1:0]       old_cls,
  input  logic             yng_vld,
  input  logic [1:0]       yng_cls,
  input  logic             stall,
  input  logic [CNT_W-1:0] load_x,
  input  logic [CNT_W-1:0] load_y,
  output logic             x_go,
  output logic             y_go,
  output logic             y_takes_yng,
  output logic [1:0]       take
);
  logic go, old_excl, yng_simple, pair_ok, solo_y;
  logic [7:0] lx, ly;

  always_comb begin
    lx = 8'(load_x);
    ly = 8'(load_y);
    go         = old_vld && !stall;
    old_excl   = (old_cls == CLS_EXCL);
    yng_simple = yng_vld && !needs_x(yng_cls);
    pair_ok    = go && !old_excl && yng_simple;
    solo_y     = go && !pair_ok && !needs_x(old_cls) && lean_to_y(lx, ly);
    x_go        = go && !solo_y;
    y_go        = pair_ok || solo_y;
    y_takes_yng = pair_ok;
    take        = pair_ok ? 2'd2 : (go ? 2'd1 : 2'd0);
  end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_dispatch_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int CNT_W = 3,
  localparam int INSTR_W = 2 + 3 * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               old_vld,
  input  logic [INSTR_W-1:0] old_ins,
  input  logic               yng_vld,
  input  logic [INSTR_W-1:0] yng_ins,
  input  logic               stall_x,
  input  logic               stall_y,
  input  logic               retire_x,
  input  logic               retire_y,
  output logic               x_vld,
  output logic [INSTR_W-1:0] x_ins,
  output logic               y_vld,
  output logic [INSTR_W-1:0] y_ins,
  output logic [1:0]         consumed
);
  logic [CNT_W-1:0] load_x, load_y;
  logic             y_takes_yng;
  wire              any_stall = stall_x || stall_y;

  pair_rules #(.CNT_W(CNT_W)) rules_i (
    .old_vld(old_vld), .old_cls(old_ins[1:0]),
    .yng_vld(yng_vld), .yng_cls(yng_ins[1:0]),
    .stall(any_stall), .load_x(load_x), .load_y(load_y),
    .x_go(x_vld), .y_go(y_vld), .y_takes_yng(y_takes_yng), .take(consumed)
  );

  assign x_ins = old_ins;
  assign y_ins = y_takes_yng ? yng_ins : old_ins;

  logic [1:0] issue_v, retire_v;
  logic [1:0][CNT_W-1:0] load_v;
  assign issue_v  = {y_vld, x_vld};
  assign retire_v = {retire_y, retire_x};

  for (genvar p = 0; p < 2; p++) begin : g_load
    pipe_load_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .issue(issue_v[p]),
      .retire(retire_v[p]), .count(load_v[p])
    );
  end
  assign load_x = load_v[0];
  assign load_y = load_v[1];

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stall |-> (consumed == 2'd0 && !x_vld && !y_vld));
  // R3
  y_simple_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> y_ins[1:0] == CLS_SIMPLE);
  // R4
  excl_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_vld && x_ins[1:0] == CLS_EXCL) |-> (!y_vld && consumed == 2'd1));
  // R9
  no_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !old_vld |-> (consumed == 2'd0 && !x_vld && !y_vld));
  // R5
  take_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consumed == 2'(32'(x_vld) + 32'(y_vld)));
endmodule

// File: tb/pair_dispatch_tb.sv
module pair_dispatch_tb_top;
  localparam int REG_W = 3;
  localparam int CNT_W = 3;
  localparam int W = 2 + 3 * REG_W;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic ov = 0, yv = 0, sx = 0, sy = 0, rx = 0, ry = 0;
  logic [W-1:0] oi = '0, yi = '0;
  logic xv_o, yv_o;
  logic [W-1:0] xi_o, yi_o;
  logic [1:0] cons_o;

  always #(TCLK/2) clk = ~clk;

  pair_dispatch #(.REG_W(REG_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .old_vld(ov), .old_ins(oi), .yng_vld(yv), .yng_ins(yi),
    .stall_x(sx), .stall_y(sy), .retire_x(rx), .retire_y(ry),
    .x_vld(xv_o), .x_ins(xi_o), .y_vld(yv_o), .y_ins(yi_o), .consumed(cons_o));

  typedef struct {
    logic xv, yv;
    logic [W-1:0] xi, yi;
    logic [1:0] cons;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cyc = 0;
  int mx = 0, my = 0;

  function automatic logic [W-1:0] mk(int cls, int d, int a, int b);
    return {REG_W'(b), REG_W'(a), REG_W'(d), 2'(cls)};
  endfunction

  task automatic drive(input logic v0, input logic [W-1:0] i0, input logic v1,
                       input logic [W-1:0] i1, input logic s_x, input logic s_y,
                       input logic r_x, input logic r_y, input string tag);
    exp_t e;
    int c0, c1;
    @(posedge clk); #1;
    ov = v0; oi = i0; yv = v1; yi = i1; sx = s_x; sy = s_y; rx = r_x; ry = r_y;
    c0 = int'(i0[1:0]); c1 = int'(i1[1:0]);
    e.xv = 0; e.yv = 0; e.xi = i0; e.yi = i0; e.cons = 0; e.tag = tag;
    if (v0 && !s_x && !s_y) begin
      case (c0)
        3: begin e.xv = 1; e.cons = 1; end
        1, 2: begin
          e.xv = 1; e.cons = 1;
          if (v1 && c1 == 0) begin e.yv = 1; e.yi = i1; e.cons = 2; end
        end
        default: begin
          e.cons = 1;
          if (v1 && c1 == 0) begin e.xv = 1; e.yv = 1; e.yi = i1; e.cons = 2; end
          else if (my < mx) e.yv = 1;
          else e.xv = 1;
        end
      endcase
    end
    q.push_back(e);
    if (e.xv && !r_x && mx < CMAX) mx++;
    else if (!e.xv && r_x && mx > 0) mx--;
    if (e.yv && !r_y && my < CMAX) my++;
    else if (!e.yv && r_y && my > 0) my--;
  endtask

  initial begin : monitor
    exp_t e;
    logic ok;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        ok = (xv_o === e.xv) && (yv_o === e.yv) && (cons_o === e.cons)
             && (!e.xv || xi_o === e.xi) && (!e.yv || yi_o === e.yi);
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s: got x=%b/%h y=%b/%h n=%0d, want x=%b/%h y=%b/%h n=%0d",
                   e.tag, xv_o, xi_o, yv_o, yi_o, cons_o, e.xv, e.xi, e.yv, e.yi, e.cons);
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        bad++; total++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [W-1:0] s_a, s_b, br, fp, ex;
    s_a = mk(0, 1, 2, 3);
    s_b = mk(0, 4, 1, 1);  // reads s_a's destination
    br  = mk(1, 0, 5, 6);
    fp  = mk(2, 7, 2, 2);
    ex  = mk(3, 3, 4, 5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: idle then lone simple on zero counters goes to X
    drive(0, '0, 0, '0, 0, 0, 0, 0, "R1 idle");
    drive(1, s_a, 0, '0, 0, 0, 0, 0, "R1 tie to X");
    // R7: X now 1, Y 0 -> Y
    drive(1, s_b, 0, '0, 0, 0, 0, 0, "R7 lean Y");
    drive(1, s_a, 0, '0, 0, 0, 0, 0, "R7 tie X");
    // R5 dependent pair
    drive(1, s_a, 1, s_b, 0, 0, 0, 0, "R5 dep pair");
    // R3
    drive(1, br, 1, s_b, 0, 0, 0, 0, "R3 br+simple");
    drive(1, fp, 1, s_a, 0, 0, 0, 0, "R3 fp+simple");
    drive(1, fp, 0, '0, 0, 0, 0, 0, "R3 fp alone");
    // R10
    drive(1, br, 1, fp, 0, 0, 0, 0, "R10 br+fp");
    drive(1, fp, 1, ex, 0, 0, 0, 0, "R10 fp+ex");
    // R4
    drive(1, ex, 1, s_a, 0, 0, 0, 0, "R4 ex+simple");
    drive(1, ex, 0, '0, 0, 0, 0, 0, "R4 ex alone");
    // R6
    drive(1, s_a, 1, br, 0, 0, 0, 0, "R6 simple+br");
    drive(1, s_b, 1, ex, 0, 0, 0, 0, "R6 simple+ex");
    // R2 stalls, then steering shows nothing counted
    drive(1, s_a, 1, s_b, 1, 0, 0, 0, "R2 stall x");
    drive(1, ex, 0, '0, 0, 1, 0, 0, "R2 stall y");
    // R9
    drive(0, s_a, 1, s_b, 0, 0, 0, 0, "R9 no old");
    // R8 saturate X, drain Y
    for (int k = 0; k < CMAX + 3; k++) drive(1, br, 0, '0, 0, 0, 0, 1, "R8 fill X");
    drive(1, s_a, 0, '0, 0, 0, 0, 0, "R8 lone to Y");
    for (int k = 0; k < 3; k++) drive(0, '0, 0, '0, 0, 0, 1, 1, "R8 drain");
    drive(1, s_a, 0, '0, 0, 0, 1, 0, "R8 issue+retire");
    for (int k = 0; k < CMAX + 2; k++) drive(0, '0, 0, '0, 0, 0, 1, 0, "R8 empty X");
    drive(1, s_b, 0, '0, 0, 0, 0, 0, "R8 floor then X");
    drive(1, s_a, 0, '0, 0, 0, 0, 0, "R7 after floor");
    for (int k = 0; k < 40; k++)
      drive(k % 5 != 0, (k % 3 == 0) ? s_a : (k % 3 == 1 ? br : fp), k % 2 == 0,
            (k % 4 == 0) ? ex : s_b, k % 11 == 0, 0, k % 3 == 0, k % 4 == 1, "R7 mix");
    drive(0, '0, 0, '0, 0, 0, 0, 0, "end");
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule